// File: doc/BRIEF.md
# Local Interrupt Timer with Programmable Divider

This block is a countdown timer for a processor's local interrupt unit. Software loads a start value. The timer counts it down at the bus clock divided by a programmable power of two. The timer runs once or repeats. Each time the count runs out, a pending counter goes up by one. The block raises an interrupt request carrying the timer entry's vector while that counter is nonzero and the timer entry is unmasked. Each delivery that is accepted takes one off the counter.

The block also holds the mask bits of six local interrupt entries. Entry 0 is the timer entry. A level input carries the controller's software-enable state. While that input is low, every entry is masked and the pending counter is held at zero. Bus decode and interrupt prioritisation sit outside the block. A write arrives as a one-cycle strobe with an index and a 32-bit word.

Top module: `lit_timer`

## Requirements
- R1: After reset, all six mask bits are 1, the current count is 0, the pending count is 0 and no request is raised. The divide field is 0, so the timer divides by 2.
- R2: The divide field is {wr_data[3], wr_data[1:0]} of a write at index 6. Bit 2 is ignored. The ratio is 2^((field+1) mod 8), so field 7 gives divide by 1, 0 gives 2, 3 gives 16 and 6 gives 128.
- R3: A write at index 7 loads wr_data as the initial and current count. It restarts the prescaler and clears the pending count. The next decrement follows ratio clock edges after the write edge.
- R4: An initial count of 0 leaves the timer stopped, with the current count reading 0 and no expiries.
- R5: In one-shot mode, the count reaches 0 at N·ratio edges after a load of N, and the pending count rises by one. The count then stays at 0 until the next load.
- R6: In periodic mode, the tick that would take the count to 0 reloads N instead and adds one pending expiry. Expiries repeat every N·ratio edges.
- R7: Entry writes use index 0 for the timer and 1 to 5 for the others. Bits 7:0 are the vector, bit 16 the mask and bit 17 periodic mode. irq_req is high exactly when timer mask is 0 and pending is nonzero, and irq_vector shows the timer vector. irq_ack together with irq_req takes one off the pending count.
- R8: In any cycle with sw_en low, all six mask bits are set and the pending count is cleared.
- R9: An entry write while sw_en is low stores mask 1 whatever bit 16 holds. With sw_en high, bit 16 is stored as written.
- R10: A write at index 6 restarts the prescaler from zero, so a tick that was about to happen is postponed by a full ratio period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write index: 0-5 entries, 6 divide, 7 initial count |
| wr_data | input | 32 | Write data |
| sw_en | input | 1 | Software-enable level of the interrupt controller |
| irq_ack | input | 1 | Controller accepted the timer request this cycle |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector of the timer entry |
| cur_count | output | 32 | Current countdown value |
| pend_count | output | 4 | Number of undelivered expiries (saturating) |
| lvt_mask | output | 6 | Mask bits of the six local entries |

## Verification
Every result is registered. A write, acknowledge or sw_en change is visible at the ports one clock edge after the edge that samples it. After a load of N, the first decrement comes ratio edges after the write edge, and expiry comes N·ratio edges after it. The request rises on the expiry edge itself. The bench drives inputs and samples outputs on falling edges. From each write it counts exactly the rising edges the requirements predict, and checks the count one edge before expiry and the pending count on the expiry edge. The prescaler-restart and divide-encoding cases are timed from the ratio that the bench computes from the field.

// File: rtl/lit_pkg.sv
`timescale 1ns/1ps
package lit_pkg;
  localparam int LVT_N    = 6;
  localparam int ADDR_W   = 3;
  localparam int PRE_W    = 7;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd6;
  localparam logic [ADDR_W-1:0] A_INIT = 3'd7;
  localparam int MASK_BIT = 16;
  localparam int MODE_BIT = 17;

  // log2 of the divide ratio for a 3-bit divide field
  function automatic logic [2:0] div_shift(input logic [2:0] field);
    return field + 3'd1;
  endfunction
endpackage

// File: rtl/lit_prescaler.sv
`timescale 1ns/1ps
module lit_prescaler import lit_pkg::*; #(
  parameter int PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [2:0] div_field,
  output logic       tick
);
  logic [PW:0]   full;
  logic [PW-1:0] limit;
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    full  = (PW+1)'(1) << div_shift(div_field);
    limit = PW'(full - (PW+1)'(1));
    tick  = run && !restart && (cnt_q == limit);
    if (restart || !run)     cnt_d = '0;
    else if (cnt_q == limit) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lit_down_counter.sv
`timescale 1ns/1ps
module lit_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] init_q, init_d, cnt_q, cnt_d;

  always_comb begin
    init_d = init_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load) begin
      init_d = load_val;
      cnt_d  = load_val;
    end else if (tick && cnt_q != '0) begin
      if (cnt_q == CNT_W'(1)) begin
        expire = 1'b1;
        cnt_d  = periodic ? init_q : '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      cnt_q  <= '0;
    end else begin
      init_q <= init_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/lit_pending.sv
`timescale 1ns/1ps
module lit_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] cnt
);
  logic [PEND_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                 cnt_d = '0;
    else if (inc && !dec && cnt_q != '1)     cnt_d = cnt_q + 1'b1;
    else if (dec && !inc && cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/lit_lvt_bank.sv
`timescale 1ns/1ps
module lit_lvt_bank import lit_pkg::*; #(
  parameter int N = LVT_N,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_vec,
  input  logic          wr_mask,
  input  logic          wr_mode,
  input  logic          sw_en,
  output logic [N-1:0]  mask_o,
  output logic [7:0]    tmr_vec,
  output logic          tmr_mode
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic hit;
    logic mask_q, mask_d;
    assign hit = wr && (wr_idx == AW'(i));

    always_comb begin
      mask_d = mask_q;
      if (hit)         mask_d = wr_mask | !sw_en;
      else if (!sw_en) mask_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= 1'b1;
      else        mask_q <= mask_d;
    end
    assign mask_o[i] = mask_q;

    if (i == 0) begin : g_tmr
      logic [7:0] vec_q, vec_d;
      logic       mode_q, mode_d;
      always_comb begin
        vec_d  = hit ? wr_vec  : vec_q;
        mode_d = hit ? wr_mode : mode_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vec_q  <= '0;
          mode_q <= 1'b0;
        end else begin
          vec_q  <= vec_d;
          mode_q <= mode_d;
        end
      end
      assign tmr_vec  = vec_q;
      assign tmr_mode = mode_q;
    end
  end
endmodule

// File: rtl/lit_timer.sv
`timescale 1ns/1ps
module lit_timer import lit_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              sw_en,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [7:0]        irq_vector,
  output logic [CNT_W-1:0]  cur_count,
  output logic [PEND_W-1:0] pend_count,
  output logic [LVT_N-1:0]  lvt_mask
);
  logic       wr_div, wr_init, wr_lvt;
  logic [2:0] div_q, div_d;
  logic       tick, expire, periodic;

  always_comb begin
    wr_div  = wr_en && (wr_addr == A_DIV);
    wr_init = wr_en && (wr_addr == A_INIT);
    wr_lvt  = wr_en && (int'(wr_addr) < LVT_N);
    div_d   = wr_div ? {wr_data[3], wr_data[1:0]} : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  lit_lvt_bank #(.N(LVT_N), .AW(ADDR_W)) u_lvt (
    .clk(clk), .rst_n(rst_n), .wr(wr_lvt), .wr_idx(wr_addr),
    .wr_vec(wr_data[7:0]), .wr_mask(wr_data[MASK_BIT]),
    .wr_mode(wr_data[MODE_BIT]), .sw_en(sw_en),
    .mask_o(lvt_mask), .tmr_vec(irq_vector), .tmr_mode(periodic)
  );

  lit_prescaler #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cur_count != '0),
    .restart(wr_div || wr_init), .div_field(div_q), .tick(tick)
  );

  lit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_init), .load_val(wr_data[CNT_W-1:0]),
    .tick(tick), .periodic(periodic), .count(cur_count), .expire(expire)
  );

  lit_pending #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(wr_init || !sw_en), .inc(expire),
    .dec(irq_req && irq_ack), .cnt(pend_count)
  );

  assign irq_req = !lvt_mask[0] && (pend_count != '0);
endmodule

// File: rtl/lit_timer_chk.sv
`timescale 1ns/1ps
module lit_timer_chk import lit_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              sw_en,
  input logic              irq_ack,
  input logic              irq_req,
  input logic [CNT_W-1:0]  cur_count,
  input logic [PEND_W-1:0] pend_count,
  input logic [LVT_N-1:0]  lvt_mask
);
  // R8
  sw_off_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> (&lvt_mask) && (pend_count == '0));
  // R4
  zero_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_INIT && wr_data == '0) |=> (cur_count == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !(wr_en && wr_addr == A_INIT)) |=> (cur_count == '0));
  // R3
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_INIT) |=> (pend_count == '0));
  // R7
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvt_mask[0] |-> !irq_req);
  // R7
  ack_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (pend_count <= $past(pend_count)));
endmodule

bind lit_timer lit_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sw_en(sw_en), .irq_ack(irq_ack), .irq_req(irq_req),
  .cur_count(cur_count), .pend_count(pend_count), .lvt_mask(lvt_mask)
);

// File: tb/lit_timer_bench.sv
`timescale 1ns/1ps
module lit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, sw_en, irq_ack, irq_req;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data, cur_count;
  logic [7:0]  irq_vector;
  logic [3:0]  pend_count;
  logic [5:0]  lvt_mask;
  int checks = 0, failures = 0;

  // {cfg[3:0], N[7:0], periodic}
  localparam logic [12:0] TBL [8] = '{
    {4'hB, 8'd5, 1'b0}, {4'h0, 8'd3, 1'b1}, {4'h1, 8'd4, 1'b0}, {4'h2, 8'd2, 1'b1},
    {4'h8, 8'd1, 1'b0}, {4'hA, 8'd2, 1'b1}, {4'h3, 8'd1, 1'b1}, {4'h4, 8'd3, 1'b0}};

  logic [3:0] cfg;
  logic [7:0] n, vec;
  logic       per;
  int         ratio, tot;

  always #2.5 clk = ~clk;

  lit_timer u_lit_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_en(sw_en), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector),
    .cur_count(cur_count), .pend_count(pend_count), .lvt_mask(lvt_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] lvt_word(input logic p, input logic m, input logic [7:0] v);
    return {14'd0, p, m, 8'd0, v};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sw_en = 1'b1; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 masks", 32'(lvt_mask), 32'h3f);
    chk("R1 count", cur_count, 0);
    chk("R1 pending", 32'(pend_count), 0);
    chk("R1 irq", 32'(irq_req), 0);

    // R1 default divide by 2: load 2 -> expiry 4 edges later
    wr(3'd0, lvt_word(1'b0, 1'b0, 8'h30));
    wr(3'd7, 32'd2);
    repeat (3) @(negedge clk);
    chk("R1 div2 before", 32'(pend_count), 0);
    @(negedge clk);
    chk("R1 div2 expiry", 32'(pend_count), 1);

    // table: divide encodings, one-shot and periodic (R2 R3 R5 R6 R7)
    for (int i = 0; i < 8; i++) begin
      cfg = TBL[i][12:9]; n = TBL[i][8:1]; per = TBL[i][0];
      vec = 8'h40 + 8'(i);
      ratio = 1 << ((int'({cfg[3], cfg[1:0]}) + 1) % 8);
      tot = int'(n) * ratio;
      wr(3'd6, 32'(cfg));
      wr(3'd0, lvt_word(per, 1'b0, vec));
      wr(3'd7, 32'(n));
      chk("R3 pending cleared", 32'(pend_count), 0);
      repeat (tot - 1) @(negedge clk);
      chk("R2 count one edge before expiry", cur_count, 1);
      chk("R2 no expiry yet", 32'(pend_count), 0);
      @(negedge clk);
      chk("R2 expiry pending", 32'(pend_count), 1);
      chk("R7 irq raised", 32'(irq_req), 1);
      chk("R7 vector", 32'(irq_vector), 32'(vec));
      if (per) begin
        chk("R6 reload", cur_count, 32'(n));
        repeat (tot - 1) @(negedge clk);
        chk("R6 second period not yet", 32'(pend_count), 1);
        @(negedge clk);
        chk("R6 second expiry", 32'(pend_count), 2);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 ack decrements", 32'(pend_count), 1);
      end else begin
        chk("R5 count at zero", cur_count, 0);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R7 ack to zero", 32'(pend_count), 0);
        chk("R7 irq drops", 32'(irq_req), 0);
        repeat (2 * ratio + 3) @(negedge clk);
        chk("R5 stays zero", cur_count, 0);
        chk("R5 no re-expiry", 32'(pend_count), 0);
      end
    end

    // R4 zero initial count
    wr(3'd7, 32'd0);
    repeat (10) @(negedge clk);
    chk("R4 count zero", cur_count, 0);
    chk("R4 no expiry", 32'(pend_count), 0);

    // R10 divide write restarts prescaler: /4, N=3
    wr(3'd6, 32'h1);
    wr(3'd0, lvt_word(1'b0, 1'b0, 8'h22));
    wr(3'd7, 32'd3);
    repeat (2) @(negedge clk);
    wr(3'd6, 32'h1);
    repeat (3) @(negedge clk);
    chk("R10 tick postponed", cur_count, 3);
    @(negedge clk);
    chk("R10 tick after full period", cur_count, 2);

    // R7 mask gating, then R8 software disable
    wr(3'd6, 32'hB);
    wr(3'd0, lvt_word(1'b1, 1'b0, 8'h21));
    wr(3'd7, 32'd4);
    repeat (4) @(negedge clk);
    chk("R7 pending before mask", 32'(pend_count), 1);
    wr(3'd0, lvt_word(1'b1, 1'b1, 8'h21));
    chk("R7 masked no irq", 32'(irq_req), 0);
    chk("R7 masked pending kept", 32'(pend_count), 1);
    wr(3'd0, lvt_word(1'b1, 1'b0, 8'h21));
    chk("R7 unmask irq", 32'(irq_req), 1);
    wr(3'd2, lvt_word(1'b0, 1'b0, 8'h11));
    chk("R9 enabled write unmasks", 32'(lvt_mask[2]), 0);
    sw_en = 1'b0;
    @(negedge clk);
    chk("R8 all masked", 32'(lvt_mask), 32'h3f);
    chk("R8 pending cleared", 32'(pend_count), 0);
    chk("R8 irq low", 32'(irq_req), 0);
    wr(3'd3, lvt_word(1'b0, 1'b0, 8'h55));
    chk("R9 forced mask", 32'(lvt_mask[3]), 1);
    sw_en = 1'b1;
    @(negedge clk);
    wr(3'd3, lvt_word(1'b0, 1'b0, 8'h55));
    chk("R9 mask as written", 32'(lvt_mask[3]), 0);

    summary();
  end
endmodule